// File: doc/BRIEF.md
# Communication Controller Shutdown Sequencer

This block brings a protocol communication controller to an orderly stop on behalf of the host. A start pulse begins the run. The sequencer first visits every message buffer from index 0 up to a configured last index. For each buffer it reads the enable flag. A buffer that is still enabled gets a disable request, and the flag is read again. This repeats until the flag clears. A buffer that is already disabled is passed over without any write.

When the last buffer is clear, the sequencer writes the halt command once. It then polls the protocol status until the status reports the halt state. The run ends with a one-cycle done pulse.

All traffic toward the controller goes through a simple request/response port. Only one request is outstanding at a time. Each request is held until the controller answers it. A per-run poll limit bounds two things: the disable attempts spent on any one buffer, and the status reads spent waiting for the halt state. Overrunning either bound ends the run with an error flag.

Top module: `ccsd_shutdown_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and req_valid_o are all 0.
- R2: A start pulse while idle makes busy_o 1 on the next cycle, and busy_o stays 1 until the run ends. A start pulse while busy_o is 1 has no effect: the run is not restarted and its last index is not replaced.
- R3: Buffers are visited in ascending order from 0 to the last index latched at start. Each visit begins with a status read (req_kind_o = 0). No buffer above the last index is ever accessed.
- R4: A buffer whose status response has bit 0 equal to 0 receives no disable write (req_kind_o = 1). The sequencer moves on to the next index.
- R5: A buffer whose status bit 0 reads 1 receives a disable write, followed by another status read. This repeats until bit 0 reads 0.
- R6: The halt command write (req_kind_o = 2, req_wdata_o = HALT_CMD, default 8'h0A) is issued exactly once per successful scan. It is issued only after every buffer up to the last index has read back disabled.
- R7: After the halt write, the protocol status is read (req_kind_o = 3) until resp_data_i equals HALT_STATE (default 8'h04). The run then ends without error.
- R8: done_o is 1 for exactly one cycle, in the cycle after the final response is accepted. busy_o is 0 in that same cycle.
- R9: If a buffer still reads enabled after poll_limit disable writes, the run ends with err_o = 1. No further buffer is accessed and no halt command is written. With poll_limit 0, any enabled buffer fails with no write.
- R10: If max(poll_limit, 1) protocol status reads in a row return something other than HALT_STATE, the run ends with err_o = 1.
- R11: Once req_valid_o rises, it and req_kind_o and req_idx_o stay unchanged until a cycle in which resp_valid_i is 1.
- R12: err_o keeps its value after the run ends. It is cleared only when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a shutdown run (taken only while idle) |
| last_idx_i | input | IDX_W | Highest buffer index to visit, latched at start |
| poll_limit_i | input | POLL_W | Attempt bound per buffer and for the halt wait, latched at start |
| req_valid_o | output | 1 | A request to the controller is pending |
| req_kind_o | output | 2 | 0 buffer status read, 1 buffer disable write, 2 command write, 3 protocol status read |
| req_idx_o | output | IDX_W | Buffer index for kinds 0 and 1 |
| req_wdata_o | output | DATA_W | Command value for kind 2, zero otherwise |
| resp_valid_i | input | 1 | Controller answers the pending request this cycle |
| resp_data_i | input | DATA_W | Read data: bit 0 is the enable flag for kind 0, the full value is the protocol state for kind 3 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 1 | Last run ended on a poll limit |

## Verification
The main function is tried with several buffer patterns:
- All buffers already disabled, which separates skipping from writing.
- All buffers clearing after one write.
- Buffers needing exactly poll_limit writes against poll_limit plus one, which pins down the boundary between success and timeout.
- Halt-state delays just under and exactly at the limit, which pin down the halt-wait timeout.

Randomised runs then mix enable masks, per-buffer clearing delays, last indexes, limits including zero, and response latencies of zero to two cycles, which show that the handshake does not depend on timing. Some runs also pulse start mid-run with a smaller last index: a restart would show up as extra status reads of low indexes and missing visits to high ones.

// File: rtl/ccsd_pkg.sv
// Shared types for the shutdown sequencer.
// Assumes: request kind codes are fixed and known to the controller side.
package ccsd_pkg;

    typedef enum logic [1:0] {
        REQ_MB_STAT = 2'd0,
        REQ_MB_DIS  = 2'd1,
        REQ_CMD     = 2'd2,
        REQ_PROTO   = 2'd3
    } ccsd_req_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_MB_RD    = 3'd1,
        ST_MB_DIS   = 3'd2,
        ST_HALT_WR  = 3'd3,
        ST_PROTO_RD = 3'd4
    } ccsd_state_e;

endpackage

// File: rtl/ccsd_buf_cursor.sv
// Buffer index cursor: walks from 0 upward one step per increment and
// flags when it sits on the latched last index.
// Assumes: the caller never increments while at_last_o is high.
module ccsd_buf_cursor #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [IDX_W-1:0] last_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             at_last_o
);

    logic [IDX_W-1:0] idx_q;

    // Hold the current buffer index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (inc_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o     = idx_q;
    assign at_last_o = (idx_q == last_i);

    // R3
    cursor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !at_last_o);

endmodule

// File: rtl/ccsd_retry_cnt.sv
// Attempt counter: counts retries against a limit and reports whether the
// limit is reached now or would be reached by one more attempt.
// Assumes: the limit is stable while counting.
module ccsd_retry_cnt #(
    parameter int POLL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic [POLL_W-1:0] limit_i,
    output logic              reached_o,
    output logic              next_reached_o
);

    logic [POLL_W-1:0] cnt_q;
    logic [POLL_W:0]   cnt_plus;

    // Track the attempts made so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare the count, and the count plus one, with the limit.
    always_comb begin
        cnt_plus       = {1'b0, cnt_q} + 1'b1;
        reached_o      = (cnt_q >= limit_i);
        next_reached_o = (cnt_plus >= {1'b0, limit_i});
    end

    // R9
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !reached_o);

endmodule

// File: rtl/ccsd_req_decode.sv
// Request decoder: turns the sequencer state into the request fields shown
// to the controller port.
// Assumes: the state is registered, so the request is glitch-free per cycle.
module ccsd_req_decode #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] HALT_CMD = 8'h0A
) (
    input  ccsd_pkg::ccsd_state_e state_i,
    output logic                  valid_o,
    output logic [1:0]            kind_o,
    output logic [DATA_W-1:0]     wdata_o
);
    import ccsd_pkg::*;

    // Map each active state to its request kind.
    always_comb begin
        valid_o = 1'b1;
        wdata_o = '0;
        kind_o  = REQ_MB_STAT;
        case (state_i)
            ST_MB_RD:    kind_o = REQ_MB_STAT;
            ST_MB_DIS:   kind_o = REQ_MB_DIS;
            ST_HALT_WR: begin
                kind_o  = REQ_CMD;
                wdata_o = HALT_CMD;
            end
            ST_PROTO_RD: kind_o = REQ_PROTO;
            default:     valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccsd_shutdown_seq.sv
// Shutdown sequencer top: disables every enabled message buffer with retries,
// then issues the halt command and waits for the halt state.
// Assumes: one request outstanding; resp_valid_i only while req_valid_o is high.
module ccsd_shutdown_seq #(
    parameter int                NUM_BUF    = 8,
    parameter int                POLL_W     = 4,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] HALT_CMD   = 8'h0A,
    parameter logic [DATA_W-1:0] HALT_STATE = 8'h04,
    localparam int               IDX_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [POLL_W-1:0] poll_limit_i,
    output logic              req_valid_o,
    output logic [1:0]        req_kind_o,
    output logic [IDX_W-1:0]  req_idx_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              resp_valid_i,
    input  logic [DATA_W-1:0] resp_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    import ccsd_pkg::*;

    ccsd_state_e       state_q, state_d;
    logic [IDX_W-1:0]  last_q;
    logic [POLL_W-1:0] limit_q;
    logic              err_q, done_q;
    logic              cur_clr, cur_inc, cur_at_last;
    logic              cnt_clr, cnt_inc, cnt_reached, cnt_next_reached;
    logic              finish, fail, accept, hs;

    ccsd_buf_cursor #(.IDX_W(IDX_W)) i_cursor (
        .clk(clk), .rst_n(rst_n), .clr_i(cur_clr), .inc_i(cur_inc),
        .last_i(last_q), .idx_o(req_idx_o), .at_last_o(cur_at_last)
    );

    ccsd_retry_cnt #(.POLL_W(POLL_W)) i_retry (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
        .limit_i(limit_q), .reached_o(cnt_reached),
        .next_reached_o(cnt_next_reached)
    );

    ccsd_req_decode #(.DATA_W(DATA_W), .HALT_CMD(HALT_CMD)) i_decode (
        .state_i(state_q), .valid_o(req_valid_o), .kind_o(req_kind_o),
        .wdata_o(req_wdata_o)
    );

    assign hs     = req_valid_o && resp_valid_i;
    assign accept = (state_q == ST_IDLE) && start_i;

    // Choose the next state and the cursor and counter controls.
    always_comb begin
        state_d = state_q;
        cur_clr = 1'b0;
        cur_inc = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        finish  = 1'b0;
        fail    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_MB_RD;
                    cur_clr = 1'b1;
                    cnt_clr = 1'b1;
                end
            end
            ST_MB_RD: begin
                if (hs) begin
                    if (!resp_data_i[0]) begin
                        cnt_clr = 1'b1;
                        if (cur_at_last) begin
                            state_d = ST_HALT_WR;
                        end else begin
                            cur_inc = 1'b1;
                        end
                    end else if (cnt_reached) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                        fail    = 1'b1;
                    end else begin
                        state_d = ST_MB_DIS;
                    end
                end
            end
            ST_MB_DIS: begin
                if (hs) begin
                    cnt_inc = 1'b1;
                    state_d = ST_MB_RD;
                end
            end
            ST_HALT_WR: begin
                if (hs) begin
                    cnt_clr = 1'b1;
                    state_d = ST_PROTO_RD;
                end
            end
            ST_PROTO_RD: begin
                if (hs) begin
                    if (resp_data_i == HALT_STATE) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else if (cnt_next_reached) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                        fail    = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Advance the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch the run settings when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            limit_q <= '0;
        end else if (accept) begin
            last_q  <= last_idx_i;
            limit_q <= poll_limit_i;
        end
    end

    // Produce the done pulse and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                err_q <= 1'b0;
            end else if (fail) begin
                err_q <= 1'b1;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !resp_valid_i) |=>
            (req_valid_o && $stable(req_kind_o) && $stable(req_idx_o)));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && (req_kind_o == REQ_MB_STAT || req_kind_o == REQ_MB_DIS))
            |-> (req_idx_o <= last_q));

    // R6
    halt_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == REQ_CMD) |-> cur_at_last);

    // R12
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !accept) |=> err_o);

endmodule

// File: tb/test_ccsd_shutdown_seq.sv
`timescale 1ns/1ps
module test_ccsd_shutdown_seq;
    localparam int NB = 8;
    localparam logic [7:0] HCMD = 8'h0A;
    localparam logic [7:0] HST  = 8'h04;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] last_idx_i = '0;
    logic [3:0] poll_limit_i = '0;
    logic       req_valid_o;
    logic [1:0] req_kind_o;
    logic [2:0] req_idx_o;
    logic [7:0] req_wdata_o;
    logic       resp_valid_i = 1'b0;
    logic [7:0] resp_data_i = '0;
    logic       busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;

    // controller model state
    bit mdl_en [NB];
    int stick [NB];
    int wr_cnt [NB];
    int rd_cnt [NB];
    int halt_cnt, ps_cnt, viol, hd_cur, last_cur, last_rd, lat;
    bit lat_mode = 1'b0;

    always #2.5 clk = ~clk;

    ccsd_shutdown_seq i_ccsd_shutdown_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_idx_i(last_idx_i),
        .poll_limit_i(poll_limit_i), .req_valid_o(req_valid_o),
        .req_kind_o(req_kind_o), .req_idx_o(req_idx_o), .req_wdata_o(req_wdata_o),
        .resp_valid_i(resp_valid_i), .resp_data_i(resp_data_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Answer one request and update the model.
    task automatic serve();
        int i;
        i = int'(req_idx_o);
        case (req_kind_o)
            2'd0: begin
                if (i > last_cur || i < last_rd || halt_cnt != 0) viol++;
                last_rd = i;
                rd_cnt[i]++;
                resp_data_i = {7'($urandom), mdl_en[i]};
            end
            2'd1: begin
                if (i != last_rd) viol++;
                wr_cnt[i]++;
                if (wr_cnt[i] >= stick[i]) mdl_en[i] = 1'b0;
                resp_data_i = 8'h00;
            end
            2'd2: begin
                halt_cnt++;
                if (req_wdata_o != HCMD) viol++;
                for (int j = 0; j <= last_cur; j++) if (mdl_en[j]) viol++;
                resp_data_i = 8'h00;
            end
            default: begin
                if (halt_cnt == 0) viol++;
                ps_cnt++;
                resp_data_i = (ps_cnt <= hd_cur) ? 8'h02 : HST;
            end
        endcase
    endtask

    // Responder with optional latency.
    always @(negedge clk) begin
        if (!rst_n) begin
            resp_valid_i = 1'b0;
            lat = 0;
        end else if (resp_valid_i) begin
            resp_valid_i = 1'b0;
        end else if (req_valid_o) begin
            if (lat > 0) lat--;
            else begin
                serve();
                resp_valid_i = 1'b1;
                lat = lat_mode ? int'($urandom_range(2, 0)) : 0;
            end
        end
    end

    // One shutdown run against expectations from the requirements.
    task automatic run(input string name, input int last, input int lim,
                       input int hd, input bit midstart);
        int expw [NB];
        int expr [NB];
        int exp_ps, exp_halt, le, n;
        bit exp_err, abort, seen_done;
        abort = 0;
        for (int i = 0; i < NB; i++) begin
            expw[i] = 0; expr[i] = 0; wr_cnt[i] = 0; rd_cnt[i] = 0;
        end
        for (int i = 0; i <= last; i++) begin
            if (!abort) begin
                if (mdl_en[i]) begin
                    if (stick[i] > lim) begin
                        expw[i] = lim; abort = 1;
                    end else expw[i] = stick[i];
                end
                expr[i] = expw[i] + 1;
            end
        end
        le = (lim == 0) ? 1 : lim;
        if (abort) begin
            exp_err = 1; exp_halt = 0; exp_ps = 0;
        end else begin
            exp_halt = 1;
            exp_ps  = (hd < le) ? hd + 1 : le;
            exp_err = (hd < le) ? 1'b0 : 1'b1;
        end
        halt_cnt = 0; ps_cnt = 0; viol = 0; hd_cur = hd; last_cur = last; last_rd = 0;

        @(negedge clk);
        start_i = 1'b1; last_idx_i = 3'(last); poll_limit_i = 4'(lim);
        @(negedge clk);
        start_i = 1'b0;
        // R2, R12: busy after start, error cleared by the accepted start
        chk(busy_o == 1'b1, "R2", {name, " busy after start"}, busy_o, 1);
        chk(err_o == 1'b0, "R12", {name, " err cleared at start"}, err_o, 0);
        n = 0; seen_done = done_o;
        while (!seen_done && n < 5000) begin
            if (midstart && n == 3) begin start_i = 1'b1; last_idx_i = 3'd0; end
            if (n == 4) start_i = 1'b0;
            @(negedge clk);
            n++;
            if (busy_o == 1'b0 && !done_o) begin
                chk(1'b0, "R2", {name, " busy dropped without done"}, 0, 1);
                break;
            end
            seen_done = done_o;
        end
        start_i = 1'b0;
        chk(seen_done, "R8", {name, " done reached"}, seen_done, 1);
        chk(busy_o == 1'b0, "R8", {name, " busy low with done"}, busy_o, 0);
        chk(err_o == exp_err, exp_abort_req(abort), {name, " err"}, err_o, exp_err);
        for (int i = 0; i < NB; i++) begin
            chk(wr_cnt[i] == expw[i], "R5", $sformatf("%s disable writes buf %0d", name, i),
                wr_cnt[i], expw[i]);
            chk(rd_cnt[i] == expr[i], "R3", $sformatf("%s status reads buf %0d", name, i),
                rd_cnt[i], expr[i]);
        end
        chk(halt_cnt == exp_halt, "R6", {name, " halt writes"}, halt_cnt, exp_halt);
        chk(ps_cnt == exp_ps, "R7", {name, " status reads (R10)"}, ps_cnt, exp_ps);
        chk(viol == 0, "R4", {name, " ordering violations"}, viol, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", {name, " done one cycle"}, done_o, 0);
        repeat (2) @(negedge clk);
        chk(err_o == exp_err, "R12", {name, " err holds"}, err_o, exp_err);
    endtask

    function automatic string exp_abort_req(input bit ab);
        return ab ? "R9" : "R10";
    endfunction

    task automatic set_all(input bit en, input int st);
        for (int i = 0; i < NB; i++) begin mdl_en[i] = en; stick[i] = st; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy_o == 0 && done_o == 0 && err_o == 0 && req_valid_o == 0, "R1",
            "outputs in reset", {busy_o, done_o, err_o, req_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && err_o == 0 && req_valid_o == 0, "R1",
            "outputs after reset", {busy_o, done_o, err_o, req_valid_o}, 0);

        set_all(0, 1); run("all_off", 7, 3, 0, 0);          // R4 skip
        set_all(1, 1); run("all_on", 7, 3, 1, 0);           // R5
        set_all(0, 1); mdl_en[7] = 1; stick[7] = 3;
        run("stick_at_limit", 7, 3, 2, 0);                   // R5 boundary
        set_all(1, 1); stick[4] = 4; run("stick_over", 7, 3, 0, 0);   // R9
        set_all(0, 1); run("halt_timeout", 5, 3, 3, 0);      // R10
        set_all(1, 2); run("last_zero", 0, 2, 0, 0);         // R3
        set_all(0, 1); run("limit_zero_ok", 7, 0, 0, 0);     // R10 floor
        set_all(0, 1); mdl_en[2] = 1; run("limit_zero_fail", 7, 0, 0, 0); // R9
        set_all(1, 2); run("start_while_busy", 7, 3, 1, 1);  // R2
        lat_mode = 1'b1;
        for (int r = 0; r < 25; r++) begin
            for (int i = 0; i < NB; i++) begin
                mdl_en[i] = 1'($urandom);
                stick[i] = int'($urandom_range(6, 1));
            end
            run($sformatf("rand%0d", r), int'($urandom_range(7, 0)),
                int'($urandom_range(5, 0)), int'($urandom_range(5, 0)),
                1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule